// File: doc/BRIEF.md
# Parity and Even-Error Concurrent Checker

This block puts a small fixed combinational function next to logic that watches the function's outputs for soft errors, without changing the function. The function has `N_IN` inputs and `M_OUT` outputs. Output `j` is the AND of input bits `j mod N_IN` and `(j+1) mod N_IN`. A fault port XORs a mask onto the function outputs, so a bench can emulate upsets. The faulted outputs are visible on `func_z`.

Two checks run side by side. In the first, an XOR tree over the outputs is paired with a predictor. The predictor derives the inverted expected parity from the inputs. Together they form a two-rail pair that catches every odd-weight error. In the second, an even-error detector matches the input/output vector against a parameter list of cubes. Each cube is a value and a care mask. The detector encodes its hit as a two-rail pair by splitting off one XOR factor. A two-rail checker merges both pairs into one error pair. An optional register holds that pair behind a reset that asserts asynchronously and releases synchronously.

Top module: `cec_top`

## Requirements
- R1: `func_z[j]` equals `in_a[j mod N_IN] & in_a[(j+1) mod N_IN]` XOR `flip_mask[j]`, combinationally.
- R2: With `flip_mask` all zero, the error pair is never equal, whatever the value of `in_a`. There are no false alarms.
- R3: Any `flip_mask` with an odd number of ones makes `err_f` equal `err_g`.
- R4: With a nonzero even-weight `flip_mask`, the pair is equal exactly when some cube matches the vector `{in_a, func_z}`. In that vector, `in_a` sits in the upper `N_IN` bits and `func_z` in the lower `M_OUT` bits. A cube matches when the vector ANDed with its care mask equals its value. Cube k sits at bits `[k*W +: W]` of the value and care parameters.
- R5: While the synchronised reset is active, the pair reads `err_f=0`, `err_g=1`.
- R6: With `REG_OUT=1`, the pair reflects the inputs present before a rising clock edge and holds until the next edge.
- R7: Shortening the cube list leaves detection of every single-bit flip intact. It only removes even-error detection for the dropped cubes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register and reset release |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_a | input | N_IN | Inputs to the guarded function |
| flip_mask | input | M_OUT | Fault injection: bits XORed onto the function outputs |
| func_z | output | M_OUT | Function outputs after fault injection |
| err_f | output | 1 | Error pair rail f |
| err_g | output | 1 | Error pair rail g; equal to err_f means error |

## Verification
The bench builds two copies with four inputs and four outputs, both with the registered output. The first uses the four-cube default list. Its cubes catch double flips at the all-zero and all-one inputs and across two families of input half-spaces. The second uses only the first cube, which shows how dropping cubes trims even-error coverage while leaving odd-error coverage whole. The 4-bit input space is swept exhaustively under the clean mask, every single flip and every double flip.

// File: rtl/cec_pkg.sv
package cec_pkg;
  // two-rail pair: valid and error-free when t != c
  typedef struct packed {
    logic t;
    logic c;
  } rail_t;

  localparam rail_t RAIL_OK_RST = 2'b01;
endpackage

// File: rtl/cec_func.sv
module cec_func #(
  parameter int N_IN  = 4,
  parameter int M_OUT = 4
) (
  input  logic [N_IN-1:0]  a,
  input  logic [M_OUT-1:0] flip,
  output logic [M_OUT-1:0] z
);
  logic [M_OUT-1:0] z_true;

  for (genvar j = 0; j < M_OUT; j++) begin : g_out
    assign z_true[j] = a[j % N_IN] & a[(j + 1) % N_IN];
  end

  assign z = z_true ^ flip;
endmodule

// File: rtl/cec_parity.sv
module cec_parity
  import cec_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int M_OUT = 4
) (
  input  logic [N_IN-1:0]  a,
  input  logic [M_OUT-1:0] z,
  output rail_t            pair
);
  logic [M_OUT-1:0] term;

  // predictor: parity of the product terms, taken from the inputs only
  for (genvar j = 0; j < M_OUT; j++) begin : g_pred
    assign term[j] = a[j % N_IN] & a[(j + 1) % N_IN];
  end

  assign pair.t = ^z;      // observed parity
  assign pair.c = ~^term;  // inverted predicted parity
endmodule

// File: rtl/cec_even_det.sv
module cec_even_det
  import cec_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int M_OUT = 4,
  parameter int NCUBE = 4,
  localparam int W    = N_IN + M_OUT,
  parameter logic [NCUBE*W-1:0] CUBE_VAL  = '0,
  parameter logic [NCUBE*W-1:0] CUBE_CARE = '0
) (
  input  logic [N_IN-1:0]  a,
  input  logic [M_OUT-1:0] z,
  output rail_t            pair
);
  logic [W-1:0]     vec;
  logic [NCUBE-1:0] hit;
  logic             det;

  assign vec = {a, z};

  for (genvar k = 0; k < NCUBE; k++) begin : g_cube
    assign hit[k] = ((vec & CUBE_CARE[k*W +: W]) == CUBE_VAL[k*W +: W]);
  end

  assign det = |hit;

  // det = e1 ^ a[0]; drive e1 and the inverse of a[0]
  assign pair.t = det ^ a[0];
  assign pair.c = ~a[0];
endmodule

// File: rtl/cec_two_rail.sv
module cec_two_rail
  import cec_pkg::*;
(
  input  rail_t p0,
  input  rail_t p1,
  output rail_t q
);
  assign q.t = (p0.t & p1.t) | (p0.c & p1.c);
  assign q.c = (p0.t & p1.c) | (p0.c & p1.t);
endmodule

// File: rtl/cec_top.sv
module cec_top
  import cec_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int M_OUT   = 4,
  parameter int NCUBE   = 4,
  parameter bit REG_OUT = 1'b1,
  localparam int W      = N_IN + M_OUT,
  parameter logic [NCUBE*W-1:0] CUBE_VAL  = 32'h090C_F003,
  parameter logic [NCUBE*W-1:0] CUBE_CARE = 32'h198C_FCF3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  in_a,
  input  logic [M_OUT-1:0] flip_mask,
  output logic [M_OUT-1:0] func_z,
  output logic             err_f,
  output logic             err_g
);
  logic [1:0] rst_pipe;
  logic       rst_sync;
  rail_t      par_pair;
  rail_t      even_pair;
  rail_t      err_d;
  rail_t      err_o;
  logic       cap_en;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  cec_func #(.N_IN(N_IN), .M_OUT(M_OUT)) u_func (
    .a(in_a), .flip(flip_mask), .z(func_z)
  );

  cec_parity #(.N_IN(N_IN), .M_OUT(M_OUT)) u_par (
    .a(in_a), .z(func_z), .pair(par_pair)
  );

  cec_even_det #(
    .N_IN(N_IN), .M_OUT(M_OUT), .NCUBE(NCUBE),
    .CUBE_VAL(CUBE_VAL), .CUBE_CARE(CUBE_CARE)
  ) u_even (
    .a(in_a), .z(func_z), .pair(even_pair)
  );

  cec_two_rail u_merge (.p0(par_pair), .p1(even_pair), .q(err_d));

  assign cap_en = 1'b1;

  if (REG_OUT) begin : g_reg
    rail_t err_q;
    rail_t err_nxt;

    always_comb begin
      err_nxt = err_q;
      if (cap_en) err_nxt = err_d;
    end

    always_ff @(posedge clk or negedge rst_sync) begin
      if (!rst_sync) err_q <= RAIL_OK_RST;
      else           err_q <= err_nxt;
    end
    assign err_o = err_q;
  end else begin : g_comb
    assign err_o = rst_sync ? err_d : RAIL_OK_RST;
  end

  assign err_f = err_o.t;
  assign err_g = err_o.c;
endmodule

// File: rtl/cec_top_chk.sv
module cec_top_chk
  import cec_pkg::*;
#(
  parameter int M_OUT   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync,
  input logic [M_OUT-1:0] flip_mask,
  input rail_t            par_pair,
  input rail_t            even_pair,
  input logic             err_f,
  input logic             err_g
);
  // parity rails stay apart when nothing is flipped (R2)
  p_parity_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync && flip_mask == '0) |-> (par_pair.t != par_pair.c));

  // detector never matches a clean vector (R4)
  p_even_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync && flip_mask == '0) |-> (even_pair.t != even_pair.c));

  if (REG_OUT) begin : g_seq
    p_odd_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync && (($countones(flip_mask) & 1) == 1)) |=> (err_f == err_g));
    p_clean_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync && flip_mask == '0) |=> (err_f != err_g));
    p_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync && (par_pair.t == par_pair.c || even_pair.t == even_pair.c))
        |=> (err_f == err_g));
  end else begin : g_comb
    p_odd_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync && (($countones(flip_mask) & 1) == 1)) |-> (err_f == err_g));
    p_clean_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync && flip_mask == '0) |-> (err_f != err_g));
    p_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sync && (par_pair.t == par_pair.c || even_pair.t == even_pair.c))
        |-> (err_f == err_g));
  end
endmodule

bind cec_top cec_top_chk #(.M_OUT(M_OUT), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .rst_sync(rst_sync), .flip_mask(flip_mask),
  .par_pair(par_pair), .even_pair(even_pair), .err_f(err_f), .err_g(err_g)
);

// File: tb/cec_top_tb_top.sv
`timescale 1ns/1ps
module cec_top_tb_top;
  localparam int N = 4;
  localparam int M = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] in_a;
  logic [M-1:0] flip_mask;
  logic [M-1:0] z_main, z_thin;
  logic         f_main, g_main, f_thin, g_thin;

  int n_cmp = 0;
  int n_bad = 0;

  // cube tables as given in the requirements: {value, care} over {a, z}
  logic [7:0] cv [4] = '{8'h03, 8'hF0, 8'h0C, 8'h09};
  logic [7:0] cc [4] = '{8'hF3, 8'hFC, 8'h8C, 8'h19};

  always #2.5 clk = ~clk;

  cec_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .flip_mask(flip_mask),
    .func_z(z_main), .err_f(f_main), .err_g(g_main)
  );

  cec_top #(.NCUBE(1), .CUBE_VAL(8'h03), .CUBE_CARE(8'hF3)) dut_thin_i (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .flip_mask(flip_mask),
    .func_z(z_thin), .err_f(f_thin), .err_g(g_thin)
  );

  function automatic logic [M-1:0] ref_z(input logic [N-1:0] a);
    logic [M-1:0] r;
    for (int j = 0; j < M; j++) r[j] = a[j % N] & a[(j + 1) % N];
    return r;
  endfunction

  function automatic bit ref_hit(input logic [7:0] v, input int ncube);
    bit h = 0;
    for (int k = 0; k < ncube; k++)
      if ((v & cc[k]) == cv[k]) h = 1;
    return h;
  endfunction

  task automatic check_err(string req, logic f, logic g, bit exp_err);
    n_cmp++;
    if ((f == g) != exp_err) begin
      n_bad++;
      $display("FAIL %s: a=%h mask=%h actual pair=%b%b (err=%0d) expected err=%0d",
               req, in_a, flip_mask, f, g, f == g, exp_err);
    end
  endtask

  task automatic apply(logic [N-1:0] a, logic [M-1:0] m);
    logic [M-1:0] zf;
    bit odd;
    bit exp_m, exp_t;
    string tag;
    @(negedge clk);
    in_a = a;
    flip_mask = m;
    @(posedge clk);
    #1;
    zf = ref_z(a) ^ m;
    n_cmp++;
    if (z_main !== zf) begin
      n_bad++;
      $display("FAIL R1: a=%h mask=%h actual z=%h expected z=%h", a, m, z_main, zf);
    end
    odd   = ($countones(m) % 2) == 1;
    exp_m = odd || (m != 0 && ref_hit({a, zf}, 4));
    exp_t = odd || (m != 0 && ref_hit({a, zf}, 1));
    tag = (m == 0) ? "R2" : (odd ? "R3" : "R4");
    check_err(tag, f_main, g_main, exp_m);
    check_err(odd ? "R7 single-flip thin list" : "R7 thin list", f_thin, g_thin, exp_t);
  endtask

  initial begin
    rst_n = 1'b0;
    in_a = '0;
    flip_mask = 4'b0001;
    repeat (4) @(posedge clk);
    #1;
    // R5: reset pair is 01 even though an odd flip is present
    n_cmp++;
    if (!(f_main == 1'b0 && g_main == 1'b1)) begin
      n_bad++;
      $display("FAIL R5: actual pair=%b%b expected 01", f_main, g_main);
    end
    @(negedge clk);
    rst_n = 1'b1;
    flip_mask = '0;
    repeat (4) @(posedge clk);

    // R6: latency check, odd flip seen only after the edge
    apply(4'h5, 4'h0);
    @(negedge clk);
    flip_mask = 4'b0100;
    #1;
    check_err("R6 hold before edge", f_main, g_main, 1'b0);
    @(posedge clk);
    #1;
    check_err("R6 after edge", f_main, g_main, 1'b1);

    // exhaustive: clean, single and double flips
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 16; m++) begin
        if ($countones(m) <= 2) apply(a[N-1:0], m[M-1:0]);
      end
    end
    // a few triple and full flips
    apply(4'h0, 4'h7);
    apply(4'hF, 4'hF);
    apply(4'h9, 4'hE);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule